// File: doc/BRIEF.md
# Interrupt Source Override with Deassertion Gap

This block is the entry stage of an interrupt controller. It watches six event lines: a two-bit clock-fault group, a two-bit system-fault group and two general-purpose lines. A rising edge on any of them latches a pending bit. Software clears pending bits by writing ones. One active-high interrupt line is raised while any enabled pending bit is set.

A diagnostic override word can take the place of all six event lines at once. This lets a test routine set and clear pending bits directly from register writes.

A second register sets the minimum time the interrupt line must stay low after it drops. Back-to-back interrupts therefore always show a clean gap of a known length to the receiving logic.

Top module: `irq_override_gap`

## Requirements
- R1: While reset is applied and right after it is released, `pend_o` is 0 and `irq_o` is 0. The override word and the gap register both reset to 0.
- R2: A 0-to-1 change on a selected source sets its pending bit at the clock edge that samples it. Bit mapping: [5:4] is the clock-fault group, [3:2] is the system-fault group, [1] is `gp0_i` and [0] is `fg0_i`. A source held high does not set the bit again after a clear.
- R3: On an edge where `clr_valid_i` is 1, pending bits whose `clr_mask_i` bit is 1 are cleared and all other bits are kept. If a bit rises on the same edge it is cleared, the set wins.
- R4: A write with `wr_sel_i`=0 loads the override word. When bits [7:6] of that word equal 2'b01, its bits [5:0] replace the six sources using the R2 mapping, and changes on the raw lines have no effect. The new selection first affects `pend_o` one edge after the write edge.
- R5: If bits [7:6] of the override word are 2'b00, 2'b10 or 2'b11, the raw lines stay in use and bits [5:0] of the word are ignored.
- R6: `irq_o` goes high one edge after `pend_o & en_i` becomes nonzero. A pending bit whose enable is 0 never raises `irq_o`.
- R7: A write with `wr_sel_i`=1 loads the gap value G (8 bits). Once `irq_o` falls, it stays low for at least G+1 clock cycles. With G=0 the minimum low time is one cycle.
- R8: `irq_o` falls one edge after `pend_o & en_i` becomes zero.
- R9: Writing a new G while a gap is running does not change that gap. The new value governs the next fall of `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = override word, 1 = gap value |
| wr_data_i | input | 8 | Write data |
| clk_err_i | input | 2 | Clock-fault event lines |
| sys_err_i | input | 2 | System-fault event lines |
| gp0_i | input | 1 | General event line A |
| fg0_i | input | 1 | General event line B |
| en_i | input | 6 | Per-bit interrupt enable, same mapping as pending |
| clr_valid_i | input | 1 | Clear strobe |
| clr_mask_i | input | 6 | Write-one-to-clear mask |
| pend_o | output | 6 | Latched pending bits |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
A wrong edge-history register shows up at `pend_o` on the very next edge. It either makes a phantom pending bit appear, or re-sets a bit that was just cleared while its source stays high. A fault in the override decode appears one edge after the write that changed the word, as pending bits that follow the wrong source. A bad gap counter first becomes visible when `irq_o` rises again. The low time is then shorter or longer than G+1 cycles, so the check must time the exact edge at which the line returns high.

// File: rtl/irq_ovr_pkg.sv
package irq_ovr_pkg;
  localparam int NSRC     = 6;
  localparam int REG_W    = 8;
  localparam int KEY_HI   = 7;
  localparam int KEY_LO   = 6;
  localparam logic [1:0] OVR_KEY = 2'b01;
  localparam logic WR_OVR = 1'b0;
  localparam logic WR_GAP = 1'b1;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_select.sv
module irq_src_select
  import irq_ovr_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ovr,
  input  logic [W-1:0] wr_data,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sel_o,
  output logic [W-1:0] ovr_q_o
);
  logic [W-1:0] ovr_q, ovr_n;
  logic         act;

  always_comb begin
    ovr_n = ovr_q;
    if (wr_ovr) ovr_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= '0;
    else        ovr_q <= ovr_n;
  end

  // R4/R5: only the exact key encoding hands the sources to the register
  assign act = (ovr_q[KEY_HI:KEY_LO] == OVR_KEY);

  always_comb begin
    if (act) sel_o = ovr_q[N-1:0];
    else     sel_o = raw_i;
  end

  assign ovr_q_o = ovr_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import irq_ovr_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sel_i,
  input  logic         clr_valid,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, pend_n, rise;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      rise[i]   = sel_i[i] & ~prev_q[i];
      // R3: a new edge outranks a clear in the same cycle
      pend_n[i] = rise[i] | (pend_q[i] & ~(clr_valid & clr_mask[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sel_i;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gap_gate.sv
module irq_gap_gate
  import irq_ovr_pkg::*;
#(
  parameter int GW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_gap,
  input  logic [GW-1:0] wr_data,
  input  logic          any_i,
  output logic          irq_o,
  output logic [GW-1:0] gap_q_o
);
  logic [GW-1:0] gap_q, gap_n, cnt_q, cnt_n;
  logic          irq_q, irq_n;

  always_comb begin
    gap_n = gap_q;
    if (wr_gap) gap_n = wr_data;
  end

  // R7/R8/R9: falling loads the gap, the output stays low while it counts down
  always_comb begin
    cnt_n = cnt_q;
    irq_n = irq_q;
    if (irq_q && !any_i) begin
      irq_n = 1'b0;
      cnt_n = gap_q;
    end else if (cnt_q != '0) begin
      irq_n = 1'b0;
      cnt_n = cnt_q - GW'(1);
    end else begin
      irq_n = any_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      gap_q <= gap_n;
      cnt_q <= cnt_n;
      irq_q <= irq_n;
    end
  end

  assign irq_o   = irq_q;
  assign gap_q_o = gap_q;
endmodule

// File: rtl/irq_override_gap.sv
module irq_override_gap
  import irq_ovr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]      clk_err_i,
  input  logic [1:0]      sys_err_i,
  input  logic            gp0_i,
  input  logic            fg0_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            clr_valid_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  src_vec_t         raw_vec, sel_vec;
  logic [REG_W-1:0] ovr_word, gap_word;
  logic             any_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // R2: fixed bit mapping of the sources
  assign raw_vec = {clk_err_i, sys_err_i, gp0_i, fg0_i};

  irq_src_select #(.N(NSRC), .W(REG_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ovr  (wr_en_i && (wr_sel_i == WR_OVR)),
    .wr_data (wr_data_i),
    .raw_i   (raw_vec),
    .sel_o   (sel_vec),
    .ovr_q_o (ovr_word)
  );

  irq_pend_latch #(.N(NSRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_i     (sel_vec),
    .clr_valid (clr_valid_i),
    .clr_mask  (clr_mask_i),
    .pend_o    (pend_o)
  );

  assign any_en = |(pend_o & en_i);

  irq_gap_gate #(.GW(REG_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_gap  (wr_en_i && (wr_sel_i == WR_GAP)),
    .wr_data (wr_data_i),
    .any_i   (any_en),
    .irq_o   (irq_o),
    .gap_q_o (gap_word)
  );
endmodule

// File: rtl/irq_override_gap_chk.sv
module irq_override_gap_chk
  import irq_ovr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [NSRC-1:0]  pend_o,
  input logic [NSRC-1:0]  en_i,
  input logic             clr_valid_i,
  input logic [NSRC-1:0]  clr_mask_i,
  input logic [REG_W-1:0] ovr_q,
  input logic [REG_W-1:0] gap_q
);
  logic [REG_W:0]   low_cnt;
  logic [REG_W-1:0] gap_lat;
  logic             armed;
  logic             ovr_act;

  assign ovr_act = (ovr_q[KEY_HI:KEY_LO] == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      gap_lat <= '0;
      armed   <= 1'b0;
    end else if (irq_o) begin
      low_cnt <= '0;
      gap_lat <= gap_q;
      armed   <= 1'b1;
    end else if (low_cnt != {(REG_W+1){1'b1}}) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  p_gap_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && armed) |-> (low_cnt >= ({1'b0, gap_lat} + 1'b1)));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(pend_o & en_i)));

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ((pend_o & en_i) == '0)) |=> !irq_o);

  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_o & $past(pend_o) & ~({NSRC{$past(clr_valid_i)}} & $past(clr_mask_i))) == '0));

  p_ovr_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_act && $past(ovr_act) && $stable(ovr_q)) |=> ((pend_o & ~$past(pend_o)) == '0));
endmodule

bind irq_override_gap irq_override_gap_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .irq_o       (irq_o),
  .pend_o      (pend_o),
  .en_i        (en_i),
  .clr_valid_i (clr_valid_i),
  .clr_mask_i  (clr_mask_i),
  .ovr_q       (ovr_word),
  .gap_q       (gap_word)
);

// File: tb/irq_override_gap_tb_top.sv
`timescale 1ns/1ps
module irq_override_gap_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en_i, wr_sel_i;
  logic [7:0] wr_data_i;
  logic [1:0] clk_err_i, sys_err_i;
  logic       gp0_i, fg0_i;
  logic [5:0] en_i;
  logic       clr_valid_i;
  logic [5:0] clr_mask_i;
  logic [5:0] pend_o;
  logic       irq_o;

  int applied = 0;
  int fails   = 0;
  bit done    = 0;

  string      tag_q[$];
  logic [5:0] pend_q[$];
  logic       irq_q[$];
  bit         use_irq_q[$];

  always #2.5 clk = ~clk;

  irq_override_gap dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .clk_err_i(clk_err_i), .sys_err_i(sys_err_i),
    .gp0_i(gp0_i), .fg0_i(fg0_i), .en_i(en_i), .clr_valid_i(clr_valid_i),
    .clr_mask_i(clr_mask_i), .pend_o(pend_o), .irq_o(irq_o)
  );

  // monitor: drains expected items after the driver queued them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (tag_q.size() > 0) begin
        string      t;
        logic [5:0] ep;
        logic       ei;
        bit         ui;
        t  = tag_q.pop_front();
        ep = pend_q.pop_front();
        ei = irq_q.pop_front();
        ui = use_irq_q.pop_front();
        applied++;
        if (pend_o !== ep || (ui && irq_o !== ei)) begin
          fails++;
          $display("FAIL %s: pend=%h irq=%b expected pend=%h irq=%b", t, pend_o, irq_o, ep, ei);
        end
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string t, input logic [5:0] p, input logic i, input bit ui);
    tag_q.push_back(t);
    pend_q.push_back(p);
    irq_q.push_back(i);
    use_irq_q.push_back(ui);
  endtask

  task automatic reg_wr(input logic s, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic clear(input logic [5:0] m);
    clr_valid_i = 1'b1; clr_mask_i = m;
    step();
    clr_valid_i = 1'b0; clr_mask_i = '0;
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = '0;
    clk_err_i = '0; sys_err_i = '0; gp0_i = 0; fg0_i = 0;
    en_i = 6'h3F; clr_valid_i = 0; clr_mask_i = '0;
    @(negedge clk);
    step(3);
    expect_out("R1 in reset", 6'h00, 1'b0, 1);
    step();
    rst_n = 1'b1;
    step(3);
    expect_out("R1 after release", 6'h00, 1'b0, 1);

    // R2 raw edge, R6 irq one edge later
    clk_err_i = 2'b10;
    step();
    expect_out("R2 clk fault edge", 6'h20, 1'b0, 1);
    step();
    expect_out("R6 irq raised", 6'h20, 1'b1, 1);
    clear(6'h20);
    expect_out("R3 cleared", 6'h00, 1'b1, 1);
    step();
    expect_out("R8 irq dropped", 6'h00, 1'b0, 1);
    step();
    expect_out("R2 level no reset", 6'h00, 1'b0, 1);
    clk_err_i = 2'b00;
    step();

    // R3 set beats clear, masked clear
    fg0_i = 1'b1;
    step();
    expect_out("R2 fg edge", 6'h01, 1'b0, 0);
    fg0_i = 1'b0;
    step();
    fg0_i = 1'b1;
    clear(6'h01);
    expect_out("R3 set wins", 6'h01, 1'b0, 0);
    clear(6'h3E);
    expect_out("R3 mask keeps bit", 6'h01, 1'b0, 0);
    clear(6'h01);
    expect_out("R3 bit cleared", 6'h00, 1'b0, 0);
    fg0_i = 1'b0;
    step(2);

    // R6 disabled bit
    en_i = 6'h3E;
    fg0_i = 1'b1;
    step();
    expect_out("R6 pend disabled", 6'h01, 1'b0, 1);
    step(2);
    expect_out("R6 no irq when disabled", 6'h01, 1'b0, 1);
    clear(6'h01);
    fg0_i = 1'b0;
    en_i = 6'h3F;
    step();

    // R7 gap of 3
    reg_wr(1'b1, 8'd3);
    sys_err_i = 2'b01;
    step();
    expect_out("R2 sys fault edge", 6'h04, 1'b0, 1);
    step();
    expect_out("R6 irq for sys", 6'h04, 1'b1, 1);
    clear(6'h04);
    step();
    expect_out("R8 fall before gap", 6'h00, 1'b0, 1);
    gp0_i = 1'b1;
    step();
    expect_out("R7 gap cycle 1", 6'h02, 1'b0, 1);
    step(2);
    expect_out("R7 gap cycle 3", 6'h02, 1'b0, 1);
    step();
    expect_out("R7 returns after G+1", 6'h02, 1'b1, 1);

    // R9 new gap value used on next fall
    reg_wr(1'b1, 8'd1);
    expect_out("R9 irq held", 6'h02, 1'b1, 1);
    clear(6'h02);
    step();
    fg0_i = 1'b1;
    step();
    expect_out("R9 gap 1 low", 6'h01, 1'b0, 1);
    step();
    expect_out("R9 returns after 2", 6'h01, 1'b1, 1);
    clear(6'h01);
    reg_wr(1'b1, 8'd0);
    step(2);

    // R4 override active (raw now 000111)
    reg_wr(1'b0, 8'h48);
    expect_out("R4 write edge", 6'h00, 1'b0, 0);
    step();
    expect_out("R4 override sets bit3", 6'h08, 1'b0, 0);
    clk_err_i = 2'b11;
    step(2);
    expect_out("R4 raw ignored", 6'h08, 1'b0, 0);
    clear(6'h08);
    step();

    // R5 other encodings keep raw lines
    reg_wr(1'b0, 8'hC8);
    step();
    expect_out("R5 enc 11 raw live", 6'h37, 1'b0, 0);
    clear(6'h3F);
    reg_wr(1'b0, 8'h88);
    step();
    expect_out("R5 enc 10 bits ignored", 6'h00, 1'b0, 0);
    sys_err_i = 2'b11;
    step();
    expect_out("R5 raw edge under enc 10", 6'h08, 1'b0, 0);
    reg_wr(1'b0, 8'h3F);
    step();
    expect_out("R5 enc 00 bits ignored", 6'h08, 1'b0, 0);

    step(2);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule